// File: doc/BRIEF.md
# Warp Memory Request Coalescer

This block takes one warp's worth of virtual addresses, one per thread, together with a mask of active threads. It reduces them to two deduplicated request streams. The first stream lists every distinct 128-byte cache line the active threads touch and goes to the data cache. The second lists every distinct 4 KB virtual page and goes to the translation lookaside buffer. Each emitted line or page carries a mask of the threads that map to it, so the returned data or translation can be scattered back to the right lanes.

The block sits between address generation and the translation and cache pipelines. The page stream is issued in groups of up to four pages per cycle, one per translation port. Both streams are ordered by the lowest thread index that first touches each line or page. A warp is accepted in one handshake. The input stays blocked until both streams have drained, and the two streams drain independently of each other.

Top module: `warp_coalescer`

## Requirements
- R1: After reset `inReady` is 1 and both `lineValid` and `pageValid` are 0.
- R2: Once a warp with a nonzero mask is accepted, `inReady` is 0 from the next cycle on. It returns to 1 on the cycle after the last line and the last page group have each been handed off.
- R3: The line stream emits one line per handshake. `lineAddr` is the virtual address shifted right by 7 (the 128-byte line number). Lines appear in ascending order of the lowest active thread index that touches them.
- R4: `lineMask` bit t is 1 exactly when thread t is active and its address falls in the emitted line. Over one warp the line masks are disjoint, and together they equal the active mask.
- R5: Each page handshake carries up to four pages. `pageSlotValid` is filled from bit 0 upward with no gaps. `pageNum` slot k (bits 20k+19..20k) is the address shifted right by 12. `pageMask` slot k (bits 32k+31..32k) holds exactly the active threads in that page.
- R6: Pages are emitted in ascending order of the lowest active thread index that touches them, within a group and across successive groups. A group has four pages whenever four or more remain.
- R7: Threads whose mask bit is 0 are ignored. Their addresses create no line or page, and their bits are never set in any output mask.
- R8: A warp with an all-zero mask is accepted, emits no line and no page, and `inReady` is 1 on the next cycle.
- R9: While `lineValid` is 1 and `lineReady` is 0, the line output holds its values. While `pageValid` is 1 and `pageReady` is 0, all page outputs hold their values.
- R10: The two streams are independent. A stalled line stream does not stop the page stream from draining, and a stalled page stream does not stop the line stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Warp request present |
| inReady | output | 1 | Block can accept a warp |
| inAddr | input | 1024 | Thread t virtual address at bits 32t+31..32t |
| inMask | input | 32 | Active-thread mask |
| lineValid | output | 1 | Line request present |
| lineReady | input | 1 | Cache accepts the line request |
| lineAddr | output | 25 | Line number (address >> 7) |
| lineMask | output | 32 | Threads in this line |
| pageValid | output | 1 | Page group present |
| pageReady | input | 1 | Translation ports accept the group |
| pageSlotValid | output | 4 | Per-slot valid, filled from slot 0 |
| pageNum | output | 80 | Per-slot page number (address >> 12) |
| pageMask | output | 128 | Per-slot thread membership |

## Verification
A corrupt remaining-thread mask causes visible errors at the ports. It either repeats a line or page, drops one, or leaves a stray thread bit in an output mask. The per-clock reference comparison catches this on the first handshake after the fault, and at the latest when `inReady` rises early or late at the end of the warp. A faulty leader search or key compare breaks the emission order or the membership masks at the very next output. A fault in the ready or valid logic shows up within one cycle as a changed held output or a wrongly raised `inReady`.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef struct packed {
    logic loadWarp;
    logic lineStep;
    logic pageStep;
  } coalStrobe_t;
endpackage

// File: rtl/coal_match.sv
// Finds the lowest remaining thread, takes its key as the leader, and
// gathers every remaining thread sharing that key.
module coal_match #(
  parameter int N     = 32,
  parameter int KEY_W = 20
) (
  input  logic [N-1:0]       remMask,
  input  logic [N*KEY_W-1:0] keys,
  output logic               hit,
  output logic [KEY_W-1:0]   leadKey,
  output logic [N-1:0]       members,
  output logic [N-1:0]       restMask
);
  always_comb begin
    logic found;
    found   = 1'b0;
    leadKey = '0;
    for (int i = 0; i < N; i++) begin
      if (remMask[i] && !found) begin
        found   = 1'b1;
        leadKey = keys[i*KEY_W +: KEY_W];
      end
    end
    hit = found;
  end

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign members[g] = remMask[g] && (keys[g*KEY_W +: KEY_W] == leadKey);
  end

  assign restMask = remMask & ~members;
endmodule

// File: rtl/coal_datapath.sv
module coal_datapath
  import coal_pkg::*;
#(
  parameter int N      = 32,
  parameter int LINE_W = 25,
  parameter int PAGE_W = 20,
  parameter int PORTS  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  coalStrobe_t         strobe,
  input  logic [N*LINE_W-1:0] lineKeysIn,
  input  logic [N*PAGE_W-1:0] pageKeysIn,
  input  logic [N-1:0]        maskIn,
  output logic                lineLeft,
  output logic                pageLeft,
  output logic [LINE_W-1:0]   lineAddr,
  output logic [N-1:0]        lineMask,
  output logic [PORTS-1:0]    pageSlotValid,
  output logic [PORTS*PAGE_W-1:0] pageNum,
  output logic [PORTS*N-1:0]  pageMask
);
  logic [N*LINE_W-1:0] lineKeys;
  logic [N*PAGE_W-1:0] pageKeys;
  logic [N-1:0]        lineRem, pageRem, lineNext;
  logic [N-1:0]        chainRem [PORTS+1];
  logic                lineHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineKeys <= '0;
      pageKeys <= '0;
      lineRem  <= '0;
      pageRem  <= '0;
    end else if (strobe.loadWarp) begin
      lineKeys <= lineKeysIn;
      pageKeys <= pageKeysIn;
      lineRem  <= maskIn;
      pageRem  <= maskIn;
    end else begin
      if (strobe.lineStep) lineRem <= lineNext;
      if (strobe.pageStep) pageRem <= chainRem[PORTS];
    end
  end

  coal_match #(.N(N), .KEY_W(LINE_W)) u_lineMatch (
    .remMask (lineRem),
    .keys    (lineKeys),
    .hit     (lineHit),
    .leadKey (lineAddr),
    .members (lineMask),
    .restMask(lineNext)
  );

  assign chainRem[0] = pageRem;
  for (genvar k = 0; k < PORTS; k++) begin : g_port
    coal_match #(.N(N), .KEY_W(PAGE_W)) u_pageMatch (
      .remMask (chainRem[k]),
      .keys    (pageKeys),
      .hit     (pageSlotValid[k]),
      .leadKey (pageNum[k*PAGE_W +: PAGE_W]),
      .members (pageMask[k*N +: N]),
      .restMask(chainRem[k+1])
    );
  end

  assign lineLeft = lineHit;
  assign pageLeft = |pageRem;
endmodule

// File: rtl/coal_control.sv
module coal_control
  import coal_pkg::*;
(
  input  logic        inValid,
  input  logic        lineReady,
  input  logic        pageReady,
  input  logic        lineLeft,
  input  logic        pageLeft,
  output logic        inReady,
  output logic        lineValid,
  output logic        pageValid,
  output coalStrobe_t strobe
);
  always_comb begin
    inReady         = !lineLeft && !pageLeft;
    lineValid       = lineLeft;
    pageValid       = pageLeft;
    strobe.loadWarp = inValid && inReady;
    strobe.lineStep = lineLeft && lineReady;
    strobe.pageStep = pageLeft && pageReady;
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import coal_pkg::*;
#(
  parameter int NUM_THREADS = 32,
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 128,
  parameter int PAGE_BYTES  = 4096,
  parameter int TLB_PORTS   = 4,
  localparam int LINE_SHIFT = $clog2(LINE_BYTES),
  localparam int PAGE_SHIFT = $clog2(PAGE_BYTES),
  localparam int LINE_W     = ADDR_W - LINE_SHIFT,
  localparam int PAGE_W     = ADDR_W - PAGE_SHIFT
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          inValid,
  output logic                          inReady,
  input  logic [NUM_THREADS*ADDR_W-1:0] inAddr,
  input  logic [NUM_THREADS-1:0]        inMask,
  output logic                          lineValid,
  input  logic                          lineReady,
  output logic [LINE_W-1:0]             lineAddr,
  output logic [NUM_THREADS-1:0]        lineMask,
  output logic                          pageValid,
  input  logic                          pageReady,
  output logic [TLB_PORTS-1:0]          pageSlotValid,
  output logic [TLB_PORTS*PAGE_W-1:0]   pageNum,
  output logic [TLB_PORTS*NUM_THREADS-1:0] pageMask
);
  coalStrobe_t strobe;
  logic lineLeft, pageLeft;
  logic [NUM_THREADS*LINE_W-1:0] lineKeysIn;
  logic [NUM_THREADS*PAGE_W-1:0] pageKeysIn;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_key
    assign lineKeysIn[t*LINE_W +: LINE_W] = inAddr[t*ADDR_W+LINE_SHIFT +: LINE_W];
    assign pageKeysIn[t*PAGE_W +: PAGE_W] = inAddr[t*ADDR_W+PAGE_SHIFT +: PAGE_W];
  end

  coal_control u_ctrl (
    .inValid  (inValid),
    .lineReady(lineReady),
    .pageReady(pageReady),
    .lineLeft (lineLeft),
    .pageLeft (pageLeft),
    .inReady  (inReady),
    .lineValid(lineValid),
    .pageValid(pageValid),
    .strobe   (strobe)
  );

  coal_datapath #(
    .N(NUM_THREADS), .LINE_W(LINE_W), .PAGE_W(PAGE_W), .PORTS(TLB_PORTS)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .lineKeysIn   (lineKeysIn),
    .pageKeysIn   (pageKeysIn),
    .maskIn       (inMask),
    .lineLeft     (lineLeft),
    .pageLeft     (pageLeft),
    .lineAddr     (lineAddr),
    .lineMask     (lineMask),
    .pageSlotValid(pageSlotValid),
    .pageNum      (pageNum),
    .pageMask     (pageMask)
  );
endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
  parameter int NT     = 32,
  parameter int LINE_W = 25,
  parameter int PAGE_W = 20,
  parameter int PORTS  = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  inValid,
  input logic                  inReady,
  input logic [NT-1:0]         inMask,
  input logic                  lineValid,
  input logic                  lineReady,
  input logic [LINE_W-1:0]     lineAddr,
  input logic [NT-1:0]         lineMask,
  input logic                  pageValid,
  input logic                  pageReady,
  input logic [PORTS-1:0]      pageSlotValid,
  input logic [PORTS*PAGE_W-1:0] pageNum,
  input logic [PORTS*NT-1:0]   pageMask
);
  logic [NT-1:0] capMask;
  always_ff @(posedge clk) begin
    if (!rstN) capMask <= '0;
    else if (inValid && inReady) capMask <= inMask;
  end

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && (inMask != '0)) |=> !inReady);

  // R8
  empty_warp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && (inMask == '0)) |=> (inReady && !lineValid && !pageValid));

  // R9
  line_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineValid && !lineReady) |=> (lineValid && $stable(lineAddr) && $stable(lineMask)));

  // R9
  page_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pageValid && !pageReady) |=> (pageValid && $stable(pageSlotValid)
                                   && $stable(pageNum) && $stable(pageMask)));

  // R5
  page_lead_chk: assert property (@(posedge clk) disable iff (!rstN)
    pageValid |-> pageSlotValid[0]);

  for (genvar k = 1; k < PORTS; k++) begin : g_slot
    // R5
    slot_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
      pageSlotValid[k] |-> pageSlotValid[k-1]);
  end

  // R7
  line_inactive_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineValid |-> ((lineMask != '0) && ((lineMask & ~capMask) == '0)));
endmodule

bind warp_coalescer coal_checker #(
  .NT(NUM_THREADS), .LINE_W(LINE_W), .PAGE_W(PAGE_W), .PORTS(TLB_PORTS)
) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inMask(inMask),
  .lineValid(lineValid), .lineReady(lineReady), .lineAddr(lineAddr), .lineMask(lineMask),
  .pageValid(pageValid), .pageReady(pageReady), .pageSlotValid(pageSlotValid),
  .pageNum(pageNum), .pageMask(pageMask)
);

// File: tb/test_warp_coalescer.sv
module test_warp_coalescer;
  localparam int NT = 32;
  localparam int AW = 32;
  localparam int LW = 25;
  localparam int PW = 20;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic [NT*AW-1:0] inAddr = '0;
  logic [NT-1:0] inMask = '0;
  logic lineValid, pageValid;
  logic lineReady = 1'b0, pageReady = 1'b0;
  logic [LW-1:0] lineAddr;
  logic [NT-1:0] lineMask;
  logic [NP-1:0] pageSlotValid;
  logic [NP*PW-1:0] pageNum;
  logic [NP*NT-1:0] pageMask;

  always #5 clk = ~clk;

  warp_coalescer i_warp_coalescer (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inAddr(inAddr),
    .inMask(inMask), .lineValid(lineValid), .lineReady(lineReady), .lineAddr(lineAddr),
    .lineMask(lineMask), .pageValid(pageValid), .pageReady(pageReady),
    .pageSlotValid(pageSlotValid), .pageNum(pageNum), .pageMask(pageMask)
  );

  int checks = 0;
  int fails = 0;
  bit running = 0;
  bit finished = 0;
  int readyMode = 0;

  logic [LW-1:0] lnKey[$];
  logic [NT-1:0] lnMsk[$];
  logic [PW-1:0] pgKey[$];
  logic [NT-1:0] pgMsk[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Reference: build expected lines and pages from the accepted warp.
  task automatic buildModel(input logic [NT*AW-1:0] a, input logic [NT-1:0] m);
    for (int t = 0; t < NT; t++) begin
      if (m[t]) begin
        logic [LW-1:0] lk;
        logic [PW-1:0] pk;
        bit fl, fp;
        lk = a[t*AW+7 +: LW];
        pk = a[t*AW+12 +: PW];
        fl = 0; fp = 0;
        foreach (lnKey[i]) if (lnKey[i] == lk) begin lnMsk[i][t] = 1'b1; fl = 1; end
        if (!fl) begin lnKey.push_back(lk); lnMsk.push_back(NT'(1) << t); end
        foreach (pgKey[i]) if (pgKey[i] == pk) begin pgMsk[i][t] = 1'b1; fp = 1; end
        if (!fp) begin pgKey.push_back(pk); pgMsk.push_back(NT'(1) << t); end
      end
    end
  endtask

  // Per-cycle comparison against the model, then ready choice and bookkeeping.
  always @(negedge clk) begin
    if (running) begin
      chk(inReady == (lnKey.size() == 0 && pgKey.size() == 0), "R2", "inReady",
          64'(inReady), 64'(lnKey.size() == 0 && pgKey.size() == 0));
      chk(lineValid == (lnKey.size() != 0), "R3", "lineValid",
          64'(lineValid), 64'(lnKey.size() != 0));
      if (lineValid && lnKey.size() != 0) begin
        chk(lineAddr == lnKey[0], "R3", "lineAddr", 64'(lineAddr), 64'(lnKey[0]));
        chk(lineMask == lnMsk[0], "R4", "lineMask", 64'(lineMask), 64'(lnMsk[0]));
      end
      chk(pageValid == (pgKey.size() != 0), "R6", "pageValid",
          64'(pageValid), 64'(pgKey.size() != 0));
      if (pageValid && pgKey.size() != 0) begin
        for (int s = 0; s < NP; s++) begin
          chk(pageSlotValid[s] == (s < pgKey.size()), "R5", "pageSlotValid",
              64'(pageSlotValid), 64'(s));
          if (s < pgKey.size()) begin
            chk(pageNum[s*PW +: PW] == pgKey[s], "R6", "pageNum",
                64'(pageNum[s*PW +: PW]), 64'(pgKey[s]));
            chk(pageMask[s*NT +: NT] == pgMsk[s], "R5", "pageMask",
                64'(pageMask[s*NT +: NT]), 64'(pgMsk[s]));
          end
        end
      end
      // Random readiness exercises holding under backpressure (R9).
      case (readyMode)
        0: begin lineReady = 1'b1; pageReady = 1'b1; end
        1: begin lineReady = 1'($urandom_range(0, 1)); pageReady = 1'($urandom_range(0, 1)); end
        2: begin lineReady = 1'b0; pageReady = 1'b1; end
        default: begin lineReady = 1'b1; pageReady = 1'b0; end
      endcase
      if (lineValid && lineReady && lnKey.size() != 0) begin
        void'(lnKey.pop_front()); void'(lnMsk.pop_front());
      end
      if (pageValid && pageReady && pgKey.size() != 0) begin
        for (int s = 0; s < NP; s++) begin
          if (pgKey.size() != 0) begin void'(pgKey.pop_front()); void'(pgMsk.pop_front()); end
        end
      end
      if (inValid && inReady) buildModel(inAddr, inMask);
    end
  end

  task automatic sendWarp(input logic [NT*AW-1:0] a, input logic [NT-1:0] m);
    bit acc;
    inAddr = a; inMask = m; inValid = 1'b1;
    do begin
      @(negedge clk); acc = inReady;
      @(posedge clk); #1;
    end while (!acc);
    inValid = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while ((lnKey.size() != 0 || pgKey.size() != 0) && n < 2000) begin
      @(posedge clk); #1; n++;
    end
    @(posedge clk); #1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    logic [NT*AW-1:0] a;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    chk(inReady == 1'b1, "R1", "inReady", 64'(inReady), 64'd1);
    chk(lineValid == 1'b0, "R1", "lineValid", 64'(lineValid), 64'd0);
    chk(pageValid == 1'b0, "R1", "pageValid", 64'(pageValid), 64'd0);
    @(posedge clk); #1;
    running = 1;

    // R3 R4: all threads in one line and one page
    for (int t = 0; t < NT; t++) a[t*AW +: AW] = 32'h0004_1000 + 32'(t * 4);
    sendWarp(a, '1); drain();

    // R5 R6: 32 distinct pages in 8 groups, random readiness
    readyMode = 1;
    for (int t = 0; t < NT; t++) a[t*AW +: AW] = 32'h1000_0000 + 32'(t * 4096) + 32'(t * 8);
    sendWarp(a, '1); drain();

    // R7: inactive threads point at unique pages and lines
    for (int t = 0; t < NT; t++)
      a[t*AW +: AW] = (t % 3 == 0) ? 32'h0008_0000 + 32'((t % 2) * 128)
                                  : 32'h7000_0000 + 32'(t * 8192);
    sendWarp(a, 32'h4924_9249); drain();

    // R8: empty warp, then immediate readiness
    sendWarp(a, '0);
    @(negedge clk);
    chk(inReady == 1'b1 && !lineValid && !pageValid, "R8", "empty warp idle",
        {61'd0, inReady, lineValid, pageValid}, 64'd4);
    @(posedge clk); #1;

    // R6: first-occurrence ordering against descending thread pattern
    readyMode = 0;
    for (int t = 0; t < NT; t++) a[t*AW +: AW] = 32'h0020_0000 + 32'(((31 - t) % 6) * 4096) + 32'(t * 256);
    sendWarp(a, '1); drain();

    // R10: line stalled, pages must still drain
    readyMode = 2;
    for (int t = 0; t < NT; t++) a[t*AW +: AW] = 32'h0300_0000 + 32'((t % 7) * 4096);
    sendWarp(a, '1);
    repeat (6) @(posedge clk);
    #1;
    @(negedge clk);
    chk(pageValid == 1'b0 && lineValid == 1'b1, "R10", "pages drained with line stalled",
        {62'd0, pageValid, lineValid}, 64'd1);
    @(posedge clk); #1;
    readyMode = 3;
    repeat (12) @(posedge clk);
    #1;
    @(negedge clk);
    chk(lineValid == 1'b0, "R10", "lines drained", 64'(lineValid), 64'd0);
    @(posedge clk); #1;
    readyMode = 0; drain();

    // Random warps over a small pool of pages and lines, random masks and readiness
    readyMode = 1;
    for (int w = 0; w < 300; w++) begin
      for (int t = 0; t < NT; t++)
        a[t*AW +: AW] = 32'h4000_0000 + 32'($urandom_range(0, 7) * 4096)
                        + 32'($urandom_range(0, 3) * 128) + 32'($urandom_range(0, 127));
      sendWarp(a, (w % 10 == 9) ? '0 : NT'($urandom));
      if (w % 4 == 0) drain();
    end
    drain();

    running = 0;
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end
endmodule